// File: doc/BRIEF.md
# Dual-Context Interrupt-Enable Register Unit

This unit holds the interrupt-enable control state of a processor core that interleaves two hardware execution contexts, called A (index 0) and B (index 1). Each context owns a 12-bit enable field and a one-bit mask flag. Software reaches this state through a small byte-wide register port with three live addresses: a low-enable register, a high-enable register and a mode register. Bit 4 of the mode register records which context is currently active.

A single pair of byte registers serves both contexts. An access normally goes to the active context. The core can, however, leave a data write pending past an instruction boundary. While such a write is pending, enable-register writes go to the context that issued it, even if a context swap has happened since then. The unit records the issuing context in a tag when the pending write is set, and releases the tag when the write commits. A swap strobe from the core asks the unit to re-evaluate the active context. The unit compares the two low bits of the mode register against a pattern that depends on the current context, and it switches context when they differ.

Top module: `ctx_irq_enable_unit`

## Requirements
- R1: After reset, both enable fields read zero, both mask flags are 1, the mode register reads 8'h0C, context A is active and no write is pending.
- R2: A write to address 2 (mode) updates mode bits 7:5 and 3:0 from the data. Bit 4, the active-context index, keeps its value.
- R3: On a swap strobe, the active index toggles when mode bits [1:0] differ from 2'b01 (context B active) or from 2'b10 (context A active). When they match, the index holds.
- R4: A read of address 0 returns the active context's enable bits [3:0] in bits 3:0, context A's mask in bit 4, context B's mask in bit 5, and zeros in bits 7:6.
- R5: A write to address 0 replaces enable bits [3:0] of the target context only. Data bit 4 loads context A's mask and data bit 5 loads context B's mask, whichever context is targeted.
- R6: A read of address 1 returns bits [11:4] of the active context's enable field. A write to address 1 replaces bits [11:4] of the target context and leaves bits [3:0] unchanged.
- R7: The target of an enable write is the context recorded in the pending tag when a write is pending, and the active context otherwise. The other context's field is untouched.
- R8: A set strobe records the active index in the pending tag, and a clear strobe returns the tag to all-ones (nothing pending). When both strobes arrive in the same cycle, the set takes effect.
- R9: When a register write, a pending set or a mode write coincides with a swap strobe, each one uses the active index from before the swap. The swap itself compares the mode bits [1:0] from before the write.
- R10: Address 3 reads as 8'h00, and writes to it change no state.
- R11: Reads are combinational from the current state. Writes, swaps and pending strobes take effect at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 low enable, 1 high enable, 2 mode, 3 unused |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data of the selected register |
| swap_req | input | 1 | Request to re-evaluate the active context |
| pend_set | input | 1 | A deferred data write was issued by the active context |
| pend_clr | input | 1 | The deferred data write committed |
| active_ctx | output | 1 | Active context index (0 = A, 1 = B) |
| ctx_a_enable | output | 12 | Enable field of context A |
| ctx_a_mask | output | 1 | Mask flag of context A |
| ctx_b_enable | output | 12 | Enable field of context B |
| ctx_b_mask | output | 1 | Mask flag of context B |

## Verification
Every state change is due one rising edge after the cycle that carries the stimulus. The bench drives inputs on the falling edge and compares all state outputs a short time after the next rising edge. Read data has no register stage, so after each step the bench walks reg_addr through all four addresses and compares reg_rdata against its model within the same half cycle. It updates the model only once per rising edge, always from the values before the edge. This keeps same-cycle collisions of swap, write and pending strobes on the correct side of the edge.

// File: rtl/ctxie_pkg.sv
package ctxie_pkg;

  typedef enum logic [1:0] {
    SEL_EN_LO = 2'd0,
    SEL_EN_HI = 2'd1,
    SEL_MODE  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  // Pattern that keeps the current context on a swap request.
  function automatic logic [1:0] keep_pattern(input logic act);
    return act ? 2'b01 : 2'b10;
  endfunction

  // True when a swap request moves to the other context.
  function automatic logic swap_toggles(input logic [1:0] low_bits, input logic act);
    return low_bits != keep_pattern(act);
  endfunction

  // Software view of a mode write: all bits but the context index follow the data.
  function automatic logic [7:0] mode_merge(input logic [7:0] old_mode,
                                            input logic [7:0] wdata,
                                            input int         act_bit);
    logic [7:0] res;
    res          = wdata;
    res[act_bit] = old_mode[act_bit];
    return res;
  endfunction

endpackage

// File: rtl/ctxie_mode_ctl.sv
module ctxie_mode_ctl #(
  parameter int         ACT_BIT  = 4,
  parameter logic [7:0] MODE_RST = 8'h0C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic [7:0] wdata,
  input  logic       swap_req,
  output logic [7:0] mode_q,
  output logic       active,
  output logic       swap_fire
);
  import ctxie_pkg::*;

  logic [7:0] mode_d;

  assign active    = mode_q[ACT_BIT];
  assign swap_fire = swap_req && swap_toggles(mode_q[1:0], mode_q[ACT_BIT]);

  always_comb begin
    mode_d = mode_wr ? mode_merge(mode_q, wdata, ACT_BIT) : mode_q;
    mode_d[ACT_BIT] = mode_q[ACT_BIT] ^ swap_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_RST;
    else        mode_q <= mode_d;
  end

endmodule

// File: rtl/ctxie_pend_tag.sv
module ctxie_pend_tag #(
  parameter int TAG_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pend_set,
  input  logic pend_clr,
  input  logic active,
  output logic pend_valid,
  output logic tag_ctx
);
  localparam logic [TAG_W-1:0] TAG_IDLE = '1;

  logic [TAG_W-1:0] tag_q;

  assign pend_valid = tag_q != TAG_IDLE;
  assign tag_ctx    = tag_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tag_q <= TAG_IDLE;
    else if (pend_set) tag_q <= TAG_W'(active);
    else if (pend_clr) tag_q <= TAG_IDLE;
  end

endmodule

// File: rtl/ctxie_ctx_slot.sv
module ctxie_ctx_slot #(
  parameter int EN_W = 12,
  parameter int LO_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lo_wr,
  input  logic            hi_wr,
  input  logic            mask_wr,
  input  logic            mask_in,
  input  logic [7:0]      wdata,
  output logic [EN_W-1:0] en_q,
  output logic            mask_q
);
  localparam int HI_W = EN_W - LO_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mask_q <= 1'b1;
    end else begin
      if (lo_wr)   en_q[LO_W-1:0]    <= wdata[LO_W-1:0];
      if (hi_wr)   en_q[EN_W-1:LO_W] <= wdata[HI_W-1:0];
      if (mask_wr) mask_q            <= mask_in;
    end
  end

endmodule

// File: rtl/ctx_irq_enable_unit.sv
module ctx_irq_enable_unit #(
  parameter int         EN_W     = 12,
  parameter int         LO_W     = 4,
  parameter int         ACT_BIT  = 4,
  parameter int         TAG_W    = 2,
  parameter logic [7:0] MODE_RST = 8'h0C
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      reg_addr,
  input  logic            reg_wr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic            swap_req,
  input  logic            pend_set,
  input  logic            pend_clr,
  output logic            active_ctx,
  output logic [EN_W-1:0] ctx_a_enable,
  output logic            ctx_a_mask,
  output logic [EN_W-1:0] ctx_b_enable,
  output logic            ctx_b_mask
);
  import ctxie_pkg::*;

  localparam int NCTX     = 2;
  localparam int HI_W     = EN_W - LO_W;
  localparam int MASK_LSB = LO_W;

  reg_sel_e        sel;
  logic            wr_lo, wr_hi, wr_mode;
  logic [7:0]      mode_q;
  logic            swap_fire;
  logic            pend_valid, tag_ctx, tgt_ctx;
  logic [EN_W-1:0] slot_en   [NCTX];
  logic            slot_mask [NCTX];
  logic [EN_W-1:0] act_en;

  assign sel     = reg_sel_e'(reg_addr);
  assign wr_lo   = reg_wr && (sel == SEL_EN_LO);
  assign wr_hi   = reg_wr && (sel == SEL_EN_HI);
  assign wr_mode = reg_wr && (sel == SEL_MODE);

  ctxie_mode_ctl #(.ACT_BIT(ACT_BIT), .MODE_RST(MODE_RST)) u_mode (
    .clk(clk), .rst_n(rst_n), .mode_wr(wr_mode), .wdata(reg_wdata),
    .swap_req(swap_req), .mode_q(mode_q), .active(active_ctx), .swap_fire(swap_fire)
  );

  ctxie_pend_tag #(.TAG_W(TAG_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .pend_set(pend_set), .pend_clr(pend_clr),
    .active(active_ctx), .pend_valid(pend_valid), .tag_ctx(tag_ctx)
  );

  assign tgt_ctx = pend_valid ? tag_ctx : active_ctx;

  for (genvar c = 0; c < NCTX; c++) begin : g_slot
    ctxie_ctx_slot #(.EN_W(EN_W), .LO_W(LO_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .lo_wr(wr_lo && (tgt_ctx == 1'(c))),
      .hi_wr(wr_hi && (tgt_ctx == 1'(c))),
      .mask_wr(wr_lo),
      .mask_in(reg_wdata[MASK_LSB + c]),
      .wdata(reg_wdata),
      .en_q(slot_en[c]),
      .mask_q(slot_mask[c])
    );
  end

  assign act_en = slot_en[active_ctx];

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_EN_LO: begin
        reg_rdata[LO_W-1:0]   = act_en[LO_W-1:0];
        reg_rdata[MASK_LSB]   = slot_mask[0];
        reg_rdata[MASK_LSB+1] = slot_mask[1];
      end
      SEL_EN_HI: reg_rdata[HI_W-1:0] = act_en[EN_W-1:LO_W];
      SEL_MODE:  reg_rdata = mode_q;
      default:   reg_rdata = '0;
    endcase
  end

  assign ctx_a_enable = slot_en[0];
  assign ctx_a_mask   = slot_mask[0];
  assign ctx_b_enable = slot_en[1];
  assign ctx_b_mask   = slot_mask[1];

endmodule

// File: rtl/ctxie_unit_chk.sv
module ctxie_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  reg_addr,
  input logic        reg_wr,
  input logic [7:0]  reg_rdata,
  input logic        swap_req,
  input logic        pend_set,
  input logic        pend_clr,
  input logic        active_ctx,
  input logic [11:0] ctx_a_enable,
  input logic        ctx_a_mask,
  input logic [11:0] ctx_b_enable,
  input logic        ctx_b_mask,
  input logic [7:0]  mode_q,
  input logic        pend_valid,
  input logic        tag_ctx,
  input logic        tgt_ctx
);

  // R2
  mode_bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 2'd2 && !swap_req |=> active_ctx == $past(active_ctx));

  // R3
  swap_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_req && (mode_q[1:0] != (active_ctx ? 2'b01 : 2'b10))
    |=> active_ctx != $past(active_ctx));

  // R3
  swap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_req && (mode_q[1:0] == (active_ctx ? 2'b01 : 2'b10))
    |=> active_ctx == $past(active_ctx));

  // R4
  lo_read_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 2'd0 |-> reg_rdata[7:4] == {2'b00, ctx_b_mask, ctx_a_mask});

  // R6
  hi_write_keeps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 2'd1 && !tgt_ctx |=> ctx_a_enable[3:0] == $past(ctx_a_enable[3:0]));

  // R7
  other_ctx_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 2'd1 && !tgt_ctx |=> ctx_b_enable == $past(ctx_b_enable));

  // R8
  pend_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_set |=> pend_valid && tag_ctx == $past(active_ctx));

  // R8
  pend_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr && !pend_set |=> !pend_valid);

  // R10
  dead_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 2'd3 && !swap_req
    |=> mode_q == $past(mode_q) && ctx_a_enable == $past(ctx_a_enable)
        && ctx_b_enable == $past(ctx_b_enable) && $stable(ctx_a_mask) && $stable(ctx_b_mask));

endmodule

bind ctx_irq_enable_unit ctxie_unit_chk i_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rdata(reg_rdata),
  .swap_req(swap_req), .pend_set(pend_set), .pend_clr(pend_clr), .active_ctx(active_ctx),
  .ctx_a_enable(ctx_a_enable), .ctx_a_mask(ctx_a_mask),
  .ctx_b_enable(ctx_b_enable), .ctx_b_mask(ctx_b_mask),
  .mode_q(mode_q), .pend_valid(pend_valid), .tag_ctx(tag_ctx), .tgt_ctx(tgt_ctx)
);

// File: tb/test_ctx_irq_enable_unit.sv
module test_ctx_irq_enable_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        swap_req = 1'b0, pend_set = 1'b0, pend_clr = 1'b0;
  logic        active_ctx;
  logic [11:0] ctx_a_enable, ctx_b_enable;
  logic        ctx_a_mask, ctx_b_mask;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model
  logic [11:0] m_en [2];
  logic        m_mask [2];
  logic [7:0]  m_mode;
  int          m_tag;   // -1 when nothing is pending

  ctx_irq_enable_unit i_ctx_irq_enable_unit (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .swap_req(swap_req),
    .pend_set(pend_set), .pend_clr(pend_clr), .active_ctx(active_ctx),
    .ctx_a_enable(ctx_a_enable), .ctx_a_mask(ctx_a_mask),
    .ctx_b_enable(ctx_b_enable), .ctx_b_mask(ctx_b_mask)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    logic act;
    act = m_mode[4];
    case (a)
      2'd0:    return {2'b00, m_mask[1], m_mask[0], m_en[act][3:0]};
      2'd1:    return m_en[act][11:4];
      2'd2:    return m_mode;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_en[c]   = '0;
      m_mask[c] = 1'b1;
    end
    m_mode = 8'h0C;
    m_tag  = -1;
  endtask

  task automatic model_step(input logic [1:0] a, input logic wr, input logic [7:0] wd,
                            input logic sw, input logic ps, input logic pc);
    logic act, tgt, tog;
    act = m_mode[4];
    tgt = (m_tag >= 0) ? m_tag[0] : act;
    tog = sw && (m_mode[1:0] != (act ? 2'b01 : 2'b10));
    if (wr && a == 2'd0) begin
      m_en[tgt][3:0] = wd[3:0];
      m_mask[0] = wd[4];
      m_mask[1] = wd[5];
    end
    if (wr && a == 2'd1) m_en[tgt][11:4] = wd;
    if (wr && a == 2'd2) m_mode = {wd[7:5], act, wd[3:0]};
    m_mode[4] = act ^ tog;
    if (ps)      m_tag = int'(act);
    else if (pc) m_tag = -1;
  endtask

  task automatic chk(input string tag, input string what, input logic [31:0] act_v,
                     input logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act_v, exp_v);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "active_ctx", 32'(active_ctx), 32'(m_mode[4]));
    chk(tag, "ctx_a_enable", 32'(ctx_a_enable), 32'(m_en[0]));
    chk(tag, "ctx_b_enable", 32'(ctx_b_enable), 32'(m_en[1]));
    chk(tag, "masks", 32'({ctx_b_mask, ctx_a_mask}), 32'({m_mask[1], m_mask[0]}));
    for (int a = 0; a < 4; a++) begin
      reg_addr = 2'(a);
      #1;
      chk(tag, $sformatf("read addr %0d", a), 32'(reg_rdata), 32'(exp_read(2'(a))));
    end
  endtask

  // Drive on the falling edge, check just after the following rising edge (R11).
  task automatic step(input string tag, input logic [1:0] a, input logic wr,
                      input logic [7:0] wd, input logic sw, input logic ps, input logic pc);
    @(negedge clk);
    reg_addr = a; reg_wr = wr; reg_wdata = wd;
    swap_req = sw; pend_set = ps; pend_clr = pc;
    #1;
    if (!wr) chk(tag, "comb read", 32'(reg_rdata), 32'(exp_read(a)));
    model_step(a, wr, wd, sw, ps, pc);
    @(posedge clk);
    #2;
    reg_wr = 1'b0; swap_req = 1'b0; pend_set = 1'b0; pend_clr = 1'b0;
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #2;
    check_all("R1");
    chk("R1", "mode read", 32'(exp_read(2'd2)), 32'h0C);

    // R3: reset mode low bits 00 toggle each time
    step("R3", 2'd3, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    step("R3", 2'd3, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    // R3: A with low bits 10 holds
    step("R2", 2'd2, 1'b1, 8'h02, 1'b0, 1'b0, 1'b0);
    step("R3", 2'd0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    // R2: data bit 4 set does not move the index
    step("R2", 2'd2, 1'b1, 8'hFD, 1'b0, 1'b0, 1'b0);
    // R3: A with 01 toggles to B, then B with 01 holds
    step("R3", 2'd1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    step("R3", 2'd1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    // R5 / R6 in B
    step("R5", 2'd0, 1'b1, 8'hE9, 1'b0, 1'b0, 1'b0);
    step("R6", 2'd1, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0);
    step("R5", 2'd0, 1'b1, 8'h13, 1'b0, 1'b0, 1'b0);
    step("R4", 2'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    // back to A with low bits 00
    step("R2", 2'd2, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
    step("R3", 2'd3, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    // R7: pending from A, swap to B, writes still go to A
    step("R8", 2'd3, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    step("R3", 2'd3, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    step("R7", 2'd1, 1'b1, 8'h3C, 1'b0, 1'b0, 1'b0);
    step("R7", 2'd0, 1'b1, 8'h07, 1'b0, 1'b0, 1'b0);
    // R8: set and clear together keeps a pending tag (now B)
    step("R8", 2'd3, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1);
    step("R7", 2'd1, 1'b1, 8'h5A, 1'b0, 1'b0, 1'b0);
    step("R8", 2'd3, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    step("R7", 2'd1, 1'b1, 8'hC3, 1'b0, 1'b0, 1'b0);
    // R9: write plus swap in one cycle goes to pre-swap context (B)
    step("R9", 2'd1, 1'b1, 8'h81, 1'b1, 1'b0, 1'b0);
    step("R9", 2'd0, 1'b1, 8'h2F, 1'b1, 1'b1, 1'b0);
    step("R9", 2'd2, 1'b1, 8'h01, 1'b1, 1'b0, 1'b0);
    step("R8", 2'd3, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    // R10: dead address
    step("R10", 2'd3, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0);

    // R11: constrained random traffic
    for (int i = 0; i < 2500; i++) begin
      logic [31:0] r;
      r = $urandom;
      step("R11", r[1:0], r[2], r[15:8], r[17:16] == 2'b00, r[20:18] == 3'b000,
           r[23:21] == 3'b000);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule